// File: doc/BRIEF.md
# Pausable Round-Robin Packet Merger

This block merges eight independent packet sources onto one egress. Each source offers two streams: a metadata stream that carries one header word per packet, and a payload stream of 256-bit beats. Every beat carries a 32-bit byte-enable field and flags that mark the first and the last beat of a packet. The block serves the sources round-robin, one whole packet at a time, so every source has equal priority. A packet is never interleaved with beats from another source.

A flow-control input carries an 8-bit pause vector together with a valid strobe. Each source can be held back on its own. The pause mask is consulted only when a new source is chosen. A pause that arrives in the middle of a packet therefore lets that packet finish and holds back only the packets that follow it. The block adds no buffering: the granted source's metadata and beats reach the egress combinationally.

Top module: `chan_pause_merge`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, both egress valids are low and every ingress ready is low. No channel is paused out of reset.
- R2: Each grant forwards exactly one metadata word. That word is the granted channel's metadata, copied unchanged. It is transferred before any payload beat of the same grant.
- R3: While the payload phase of a grant is open, the granted channel's beat is forwarded in the same cycle with data, byte enable, first flag and last flag unchanged.
- R4: A grant is kept from its metadata transfer until its beat with the last flag set (1) is transferred. Meanwhile no other channel sees a ready. When no grant is held, the next grant is taken at the following clock edge, and its metadata is offered from the cycle after that edge.
- R5: A new grant goes to the first eligible channel, searching upward with wrap-around from the channel after the one granted most recently. A channel is eligible when its metadata valid is high and it is not paused. Ineligible channels are skipped.
- R6: Bit i of the pause vector set to 1 pauses channel i, and 0 resumes it. The vector is latched only in cycles where pause valid is high; in all other cycles its value is ignored. A paused channel receives no grant, even with metadata waiting.
- R7: Pausing the channel that holds the grant in the middle of a packet does not cut the packet short. Its remaining beats are forwarded, and later packets from that channel wait for a resume.
- R8: After reset the search starts at channel 0, so channel 0 wins when all channels request at once.
- R9: An ingress ready is high only for the granted channel, only in the matching phase (metadata or payload), and only when the corresponding egress ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inMetaValid | input | 8 | Per-channel metadata valid |
| inMetaData | input | 512 | Per-channel metadata words, channel i at bits [64i+63:64i] |
| inMetaReady | output | 8 | Per-channel metadata ready |
| inBeatValid | input | 8 | Per-channel payload valid |
| inBeatData | input | 2048 | Per-channel payload data, channel i at bits [256i+255:256i] |
| inBeatKeep | input | 256 | Per-channel byte enables, channel i at bits [32i+31:32i] |
| inBeatFirst | input | 8 | Per-channel first-beat flag |
| inBeatLast | input | 8 | Per-channel last-beat flag |
| inBeatReady | output | 8 | Per-channel payload ready |
| pauseValid | input | 1 | Strobe that latches pauseVec |
| pauseVec | input | 8 | Per-channel pause (1) or resume (0) |
| outMetaValid | output | 1 | Egress metadata valid |
| outMetaData | output | 64 | Egress metadata word |
| outMetaReady | input | 1 | Egress metadata ready |
| outBeatValid | output | 1 | Egress payload valid |
| outBeatData | output | 256 | Egress payload data |
| outBeatKeep | output | 32 | Egress byte enables |
| outBeatFirst | output | 1 | Egress first-beat flag |
| outBeatLast | output | 1 | Egress last-beat flag |
| outBeatReady | input | 1 | Egress payload ready |

## Verification
The hardest case to reach is a pause that lands on the channel that owns the grant while its packet is still in flight, with another packet from the same channel already waiting. The stimulus makes this happen on purpose. It gives one channel two long packets, steps the clock until a cycle-level reference model shows that channel in its payload phase with at least one beat already taken, and pulses the pause vector at exactly that point. It then confirms that the open packet drains and that the second metadata word stays held back until the resume. Random phases add source bubbles, egress backpressure and pause pulses at random times, so that pauses also meet grants in every phase.

// File: rtl/merge_pkg.sv
package merge_pkg;
  // control -> datapath: which phase of the current grant is open
  typedef struct packed {
    logic metaOpen;
    logic beatOpen;
  } gateStrobes_t;

  // datapath -> control: transfers completed this cycle
  typedef struct packed {
    logic metaTaken;
    logic endTaken;
  } xferEvents_t;
endpackage

// File: rtl/merge_ctrl.sv
module merge_ctrl
  import merge_pkg::*;
#(
  parameter int NCH = 8,
  localparam int IW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] metaValid,
  input  logic           pauseValid,
  input  logic [NCH-1:0] pauseVec,
  input  xferEvents_t    ev,
  output gateStrobes_t   gate,
  output logic [IW-1:0]  owner
);
  logic           busy, metaPend, found;
  logic [IW-1:0]  lastPtr, pickIdx, cIdx;
  logic [NCH-1:0] pausedQ;

  // rotating search that starts one past the last grant
  always_comb begin
    found   = 1'b0;
    pickIdx = '0;
    cIdx    = '0;
    for (int k = 1; k <= NCH; k++) begin
      cIdx = IW'((int'(lastPtr) + k) % NCH);
      if (!found && metaValid[cIdx] && !pausedQ[cIdx]) begin
        found   = 1'b1;
        pickIdx = cIdx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      metaPend <= 1'b0;
      owner    <= '0;
      lastPtr  <= IW'(NCH - 1);
      pausedQ  <= '0;
    end else begin
      if (pauseValid) pausedQ <= pauseVec;
      if (!busy) begin
        if (found) begin
          busy     <= 1'b1;
          metaPend <= 1'b1;
          owner    <= pickIdx;
          lastPtr  <= pickIdx;
        end
      end else begin
        if (ev.metaTaken) metaPend <= 1'b0;
        if (ev.endTaken)  busy     <= 1'b0;
      end
    end
  end

  always_comb begin
    gate.metaOpen = busy && metaPend;
    gate.beatOpen = busy && !metaPend;
  end

  // R4
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ev.endTaken) |=> (busy && $stable(owner)));

  // R6
  paused_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !(|($past(pausedQ) & (NCH'(1) << owner))));

  // R2
  single_meta_chk: assert property (@(posedge clk) disable iff (!rstN)
    ev.metaTaken |=> !gate.metaOpen);
endmodule

// File: rtl/merge_datapath.sv
module merge_datapath
  import merge_pkg::*;
#(
  parameter int NCH = 8,
  parameter int MW  = 64,
  parameter int DW  = 256,
  localparam int KW = DW / 8,
  localparam int IW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobes_t      gate,
  input  logic [IW-1:0]     owner,
  input  logic [NCH-1:0]    metaValid,
  input  logic [NCH*MW-1:0] metaData,
  output logic [NCH-1:0]    metaReady,
  input  logic [NCH-1:0]    beatValid,
  input  logic [NCH*DW-1:0] beatData,
  input  logic [NCH*KW-1:0] beatKeep,
  input  logic [NCH-1:0]    beatFirst,
  input  logic [NCH-1:0]    beatLast,
  output logic [NCH-1:0]    beatReady,
  output logic              outMetaValid,
  output logic [MW-1:0]     outMetaData,
  input  logic              outMetaReady,
  output logic              outBeatValid,
  output logic [DW-1:0]     outBeatData,
  output logic [KW-1:0]     outBeatKeep,
  output logic              outBeatFirst,
  output logic              outBeatLast,
  input  logic              outBeatReady,
  output xferEvents_t       ev
);
  always_comb begin
    outMetaData = '0;
    outBeatData = '0;
    outBeatKeep = '0;
    for (int i = 0; i < NCH; i++) begin
      if (owner == IW'(i)) begin
        outMetaData = metaData[i*MW +: MW];
        outBeatData = beatData[i*DW +: DW];
        outBeatKeep = beatKeep[i*KW +: KW];
      end
    end
    outMetaValid = gate.metaOpen && metaValid[owner];
    outBeatValid = gate.beatOpen && beatValid[owner];
    outBeatFirst = beatFirst[owner];
    outBeatLast  = beatLast[owner];
    ev.metaTaken = outMetaValid && outMetaReady;
    ev.endTaken  = outBeatValid && outBeatReady && outBeatLast;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_rdy
    assign metaReady[i] = gate.metaOpen && (owner == IW'(i)) && outMetaReady;
    assign beatReady[i] = gate.beatOpen && (owner == IW'(i)) && outBeatReady;
  end

  // R9
  ready_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(metaReady | beatReady));

  // R4
  beat_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|beatReady) |-> (gate.beatOpen && !gate.metaOpen));
endmodule

// File: rtl/chan_pause_merge.sv
module chan_pause_merge
  import merge_pkg::*;
#(
  parameter int NCH = 8,
  parameter int MW  = 64,
  parameter int DW  = 256,
  localparam int KW = DW / 8,
  localparam int IW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH-1:0]    inMetaValid,
  input  logic [NCH*MW-1:0] inMetaData,
  output logic [NCH-1:0]    inMetaReady,
  input  logic [NCH-1:0]    inBeatValid,
  input  logic [NCH*DW-1:0] inBeatData,
  input  logic [NCH*KW-1:0] inBeatKeep,
  input  logic [NCH-1:0]    inBeatFirst,
  input  logic [NCH-1:0]    inBeatLast,
  output logic [NCH-1:0]    inBeatReady,
  input  logic              pauseValid,
  input  logic [NCH-1:0]    pauseVec,
  output logic              outMetaValid,
  output logic [MW-1:0]     outMetaData,
  input  logic              outMetaReady,
  output logic              outBeatValid,
  output logic [DW-1:0]     outBeatData,
  output logic [KW-1:0]     outBeatKeep,
  output logic              outBeatFirst,
  output logic              outBeatLast,
  input  logic              outBeatReady
);
  gateStrobes_t  gate;
  xferEvents_t   ev;
  logic [IW-1:0] owner;

  merge_ctrl #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rstN(rstN), .metaValid(inMetaValid),
    .pauseValid(pauseValid), .pauseVec(pauseVec),
    .ev(ev), .gate(gate), .owner(owner)
  );

  merge_datapath #(.NCH(NCH), .MW(MW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .gate(gate), .owner(owner),
    .metaValid(inMetaValid), .metaData(inMetaData), .metaReady(inMetaReady),
    .beatValid(inBeatValid), .beatData(inBeatData), .beatKeep(inBeatKeep),
    .beatFirst(inBeatFirst), .beatLast(inBeatLast), .beatReady(inBeatReady),
    .outMetaValid(outMetaValid), .outMetaData(outMetaData),
    .outMetaReady(outMetaReady), .outBeatValid(outBeatValid),
    .outBeatData(outBeatData), .outBeatKeep(outBeatKeep),
    .outBeatFirst(outBeatFirst), .outBeatLast(outBeatLast),
    .outBeatReady(outBeatReady), .ev(ev)
  );
endmodule

// File: tb/sim_chan_pause_merge.sv
`timescale 1ns/1ps
module sim_chan_pause_merge;
  localparam int N = 8;
  localparam int MW = 64;
  localparam int DW = 256;
  localparam int KW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0] inMetaValid, inMetaReady, inBeatValid, inBeatFirst, inBeatLast, inBeatReady;
  logic [N*MW-1:0] inMetaData;
  logic [N*DW-1:0] inBeatData;
  logic [N*KW-1:0] inBeatKeep;
  logic pauseValid;
  logic [N-1:0] pauseVec;
  logic outMetaValid, outMetaReady, outBeatValid, outBeatFirst, outBeatLast, outBeatReady;
  logic [MW-1:0] outMetaData;
  logic [DW-1:0] outBeatData;
  logic [KW-1:0] outBeatKeep;

  chan_pause_merge u0 (.*);

  int tests = 0, fails = 0;
  int total[N], mpk[N], bpk[N], bb[N];
  int dirLen = 2, salt = 3;
  bit rnd = 0, pPend = 0;
  logic [N-1:0] pVal = '0;
  // reference model state
  bit rBusy = 0, rPend = 0;
  int rOwn = 0, rLast = N - 1;
  logic [N-1:0] rPaused = '0;
  int glog[256];
  int gcnt = 0;

  function automatic int plen(int c, int p);
    if (dirLen > 0) return dirLen;
    return ((c * 5 + p * 3 + salt) % 5) + 1;
  endfunction
  function automatic logic [MW-1:0] metaWord(int c, int p);
    return {8'(c), 16'(p), 32'(c * 977 + p * 31 + salt), 8'h5a};
  endfunction
  function automatic logic [DW-1:0] beatWord(int c, int p, int b);
    return {8{32'((c << 24) | (p << 8) | b) ^ 32'(salt)}};
  endfunction
  function automatic logic [KW-1:0] keepWord(int c, int p, int b);
    return 32'(c * 131 + p * 17 + b * 7 + salt) | 32'h1;
  endfunction
  function automatic bit drained();
    for (int c = 0; c < N; c++) if (bpk[c] != total[c]) return 0;
    return 1;
  endfunction

  task automatic chk(bit ok, string tag, logic [255:0] act, logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    logic [N-1:0] expMR, expBR, elig;
    bit mFire, bFire, expMV, expBV;
    @(negedge clk);
    for (int c = 0; c < N; c++) begin
      bit gap;
      int bpl;
      gap = rnd && ($urandom % 5 == 0);
      inMetaValid[c] = (mpk[c] < total[c]) && !gap;
      inMetaData[c*MW +: MW] = metaWord(c, mpk[c]);
      gap = rnd && ($urandom % 5 == 0);
      bpl = plen(c, bpk[c]);
      inBeatValid[c] = (bpk[c] < total[c]) && !gap;
      inBeatData[c*DW +: DW] = beatWord(c, bpk[c], bb[c]);
      inBeatKeep[c*KW +: KW] = keepWord(c, bpk[c], bb[c]);
      inBeatFirst[c] = (bb[c] == 0);
      inBeatLast[c] = (bb[c] == bpl - 1);
    end
    outMetaReady = rnd ? ($urandom % 3 != 0) : 1'b1;
    outBeatReady = rnd ? ($urandom % 3 != 0) : 1'b1;
    pauseValid = pPend;
    pauseVec = pPend ? pVal : 8'hff;  // garbage while not strobed (R6)
    #2;
    expMV = rBusy && rPend && inMetaValid[rOwn];
    expBV = rBusy && !rPend && inBeatValid[rOwn];
    chk(outMetaValid == expMV, "R2 meta valid", 256'(outMetaValid), 256'(expMV));
    if (expMV)
      chk(outMetaData == inMetaData[rOwn*MW +: MW], "R2 meta word", 256'(outMetaData),
          256'(inMetaData[rOwn*MW +: MW]));
    chk(outBeatValid == expBV, "R4 beat valid", 256'(outBeatValid), 256'(expBV));
    if (expBV) begin
      chk(outBeatData == inBeatData[rOwn*DW +: DW], "R3 beat data", outBeatData,
          inBeatData[rOwn*DW +: DW]);
      chk({outBeatKeep, outBeatFirst, outBeatLast} ==
          {inBeatKeep[rOwn*KW +: KW], inBeatFirst[rOwn], inBeatLast[rOwn]},
          "R3 beat keep/flags", 256'({outBeatKeep, outBeatFirst, outBeatLast}),
          256'({inBeatKeep[rOwn*KW +: KW], inBeatFirst[rOwn], inBeatLast[rOwn]}));
    end
    expMR = (expMV || (rBusy && rPend)) && outMetaReady ? (N'(1) << rOwn) : '0;
    expBR = (rBusy && !rPend) && outBeatReady ? (N'(1) << rOwn) : '0;
    chk(inMetaReady == expMR, "R9 meta ready", 256'(inMetaReady), 256'(expMR));
    chk(inBeatReady == expBR, "R9 beat ready", 256'(inBeatReady), 256'(expBR));
    // transfers at the coming edge
    mFire = expMV && outMetaReady;
    bFire = expBV && outBeatReady;
    if (mFire) begin
      if (gcnt < 256) glog[gcnt] = rOwn;
      gcnt++;
      mpk[rOwn]++;
      rPend = 0;
    end
    if (bFire) begin
      if (inBeatLast[rOwn]) begin
        bpk[rOwn]++;
        bb[rOwn] = 0;
        rBusy = 0;
      end else bb[rOwn]++;
    end else if (!rBusy) begin
      elig = inMetaValid & ~rPaused;
      for (int k = 1; k <= N; k++) begin
        int cand;
        cand = (rLast + k) % N;
        if (!rBusy && elig[cand]) begin
          rBusy = 1; rPend = 1; rOwn = cand; rLast = cand;
        end
      end
    end
    if (pPend) rPaused = pVal;
    pPend = 0;
  endtask

  task automatic runDrain(int lim);
    for (int i = 0; i < lim && !drained(); i++) step();
  endtask

  task automatic pulsePause(logic [N-1:0] v);
    pVal = v; pPend = 1; step();
  endtask

  initial begin : watchdog
    for (int i = 0; i < 180000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base, m2, m4;
    for (int c = 0; c < N; c++) begin total[c] = 0; mpk[c] = 0; bpk[c] = 0; bb[c] = 0; end
    $urandom(32'd7781);
    inMetaValid = '0; inBeatValid = '0; inMetaData = '0; inBeatData = '0; inBeatKeep = '0;
    inBeatFirst = '0; inBeatLast = '0; pauseValid = 0; pauseVec = '0;
    outMetaReady = 1; outBeatReady = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1 during reset
    chk({outMetaValid, outBeatValid, inMetaReady, inBeatReady} == '0, "R1 reset outputs",
        256'({outMetaValid, outBeatValid, inMetaReady, inBeatReady}), 0);
    @(negedge clk); rstN = 1;
    #1;
    chk({outMetaValid, outBeatValid, inMetaReady, inBeatReady} == '0, "R1 after release",
        256'({outMetaValid, outBeatValid, inMetaReady, inBeatReady}), 0);

    // R8 / R5: all channels request together, none paused after reset (R1)
    for (int c = 0; c < N; c++) total[c] = 1;
    runDrain(400);
    for (int i = 0; i < N; i++)
      chk(glog[i] == i, i == 0 ? "R8 first grant" : "R5 rotation", 256'(glog[i]), 256'(i));

    // R5: skip idle channels, continue after the last grant
    total[2] += 2; total[5] += 2; total[6] += 2;
    base = gcnt;
    runDrain(400);
    begin
      int expo[6] = '{2, 5, 6, 2, 5, 6};
      for (int i = 0; i < 6; i++)
        chk(glog[base + i] == expo[i], "R5 skip order", 256'(glog[base + i]), 256'(expo[i]));
    end

    // R6: paused channel with waiting metadata is not granted
    pulsePause(8'h04);
    m2 = mpk[2];
    total[2] += 2; total[3] += 1;
    repeat (60) step();
    chk(mpk[2] == m2, "R6 paused no grant", 256'(mpk[2]), 256'(m2));
    chk(bpk[3] == total[3], "R6 other channel served", 256'(bpk[3]), 256'(total[3]));
    pulsePause(8'h00);
    runDrain(400);
    chk(mpk[2] == m2 + 2, "R6 resume grants", 256'(mpk[2]), 256'(m2 + 2));

    // R7: pause the owner mid-packet
    dirLen = 6;
    m4 = mpk[4];
    total[4] += 2;
    for (int i = 0; i < 100 && !(rBusy && rOwn == 4 && !rPend && bb[4] >= 1); i++) step();
    pulsePause(8'h10);
    for (int i = 0; i < 40 && rBusy; i++) step();
    chk(bpk[4] == total[4] - 1, "R7 packet completes", 256'(bpk[4]), 256'(total[4] - 1));
    repeat (30) step();
    chk(mpk[4] == m4 + 1, "R7 next packet held", 256'(mpk[4]), 256'(m4 + 1));
    pulsePause(8'h00);
    runDrain(400);
    chk(mpk[4] == m4 + 2, "R7 resumed", 256'(mpk[4]), 256'(m4 + 2));

    // random traffic with backpressure, bubbles and pause pulses
    dirLen = 0; rnd = 1;
    for (int round = 0; round < 6; round++) begin
      for (int c = 0; c < N; c++) total[c] += $urandom % 6;
      for (int i = 0; i < 700; i++) begin
        if ($urandom % 40 == 0) pulsePause(N'($urandom));
        else step();
      end
    end
    pulsePause(8'h00);
    runDrain(20000);
    rnd = 0;
    runDrain(1000);
    chk(drained(), "R2 all packets delivered", 256'(drained()), 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule